// File: doc/BRIEF.md
# Time-Offset Dual-Redundant Result Checker

This block runs two identical copies of a small two-stage pipelined arithmetic unit. The primary copy sees the operands in the cycle they arrive, and only its result drives the output port. The shadow copy sees the same operands a fixed number of cycles later. A delay line of the same length on the primary result lines it up with the shadow result, and the two are compared every cycle. Because the copies are offset in time, a disturbance that hits both at once, such as a clock glitch, shows up as a mismatch and not as the same wrong answer in both copies.

The block only reports disagreement. A mismatch sets an error flag that stays set until it is cleared, and other logic decides what to do about it. A `fault_mask` input XORs onto the primary result, so a test can model a flipped bit in the primary copy.

The checker is a three-state machine. It starts in FILL after reset. While it is in FILL, comparison is masked until both delay lines have filled, which takes LAG cycles. It then moves to WATCH. A live mismatch in WATCH, meaning one found while `cmp_en` is high, moves it to TRIPPED. TRIPPED returns to WATCH when `err_clr` is high in a cycle with no live mismatch. In every other cycle TRIPPED holds.

Top module: `lockstep_checker`

## Requirements
- R1: `res_out` shows the result of operands applied in cycle n, two cycles later in cycle n+2. `op_sel` selects the operation: 0 adds a+b, 1 subtracts a-b, 2 XORs a^b, 3 ANDs a&b. Add and subtract wrap modulo 2^DATA_W.
- R2: While `rst_n` is low, `res_out` is 0 and `err_flag` is 0.
- R3: `res_out` comes only from the primary copy. `fault_mask` is XORed onto it in the same cycle.
- R4: A primary result corrupted by `fault_mask` in cycle k raises `err_flag` in cycle k+LAG, and not before.
- R5: Without any `fault_mask` activity, `err_flag` stays 0 for any sequence of operands.
- R6: Once raised, `err_flag` stays 1 until `err_clr` is applied.
- R7: `err_clr` high in a cycle with no live mismatch brings `err_flag` to 0 in the next cycle.
- R8: `err_clr` high in the same cycle as a live mismatch leaves `err_flag` at 1.
- R9: A mismatch that reaches the compare point while `cmp_en` is 0 is ignored. Nothing is latched, and the flag stays 0 after `cmp_en` returns to 1.
- R10: For the first LAG cycles after reset is released, comparison is masked and `err_flag` stays 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| opd_a | input | DATA_W | First operand |
| opd_b | input | DATA_W | Second operand |
| op_sel | input | 2 | Operation select (0 add, 1 sub, 2 xor, 3 and) |
| cmp_en | input | 1 | Enables the comparison |
| err_clr | input | 1 | Clears the sticky error |
| fault_mask | input | DATA_W | Bits to invert on the primary result |
| res_out | output | DATA_W | Primary result |
| err_flag | output | 1 | Sticky mismatch flag |

## Verification
Some rules are checked by assertions on every cycle. A tripped flag holds unless cleared. A clear with no live mismatch releases the flag. A disabled compare never trips the flag. No mismatch occurs unless a fault was injected within the last LAG cycles.

Other behaviour can only be shown by the bench scenarios. These are:
- the exact cycle in which a single-bit corruption is reported;
- a clear that coincides with a mismatch;
- the arithmetic results;
- the masked window after reset.

// File: rtl/lkst_pkg.sv
package lkst_pkg;

    localparam int OP_W = 2;

    typedef enum logic [OP_W-1:0] {
        OP_ADD = 2'd0,
        OP_SUB = 2'd1,
        OP_XOR = 2'd2,
        OP_AND = 2'd3
    } alu_op_e;

    typedef enum logic [1:0] {
        CK_FILL    = 2'd0,
        CK_WATCH   = 2'd1,
        CK_TRIPPED = 2'd2
    } chk_state_e;

endpackage

// File: rtl/lkst_delay.sv
module lkst_delay #(
    parameter int WIDTH = 8,
    parameter int DEPTH = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] stg [DEPTH];

    generate
        for (genvar i = 0; i < DEPTH; i++) begin : g_stage
            if (i == 0) begin : g_head
                always_ff @(posedge clk) begin
                    if (!rst_n) stg[i] <= '0;
                    else        stg[i] <= d;
                end
            end else begin : g_tail
                always_ff @(posedge clk) begin
                    if (!rst_n) stg[i] <= '0;
                    else        stg[i] <= stg[i-1];
                end
            end
        end
    endgenerate

    assign q = stg[DEPTH-1];
endmodule

// File: rtl/lkst_alu.sv
module lkst_alu
    import lkst_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    input  alu_op_e           op,
    input  logic [DATA_W-1:0] flip,
    output logic [DATA_W-1:0] res
);
    logic [DATA_W-1:0] a_q, b_q, res_q, res_d;
    alu_op_e           op_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            a_q  <= '0;
            b_q  <= '0;
            op_q <= OP_ADD;
        end else begin
            a_q  <= a;
            b_q  <= b;
            op_q <= op;
        end
    end

    always_comb begin
        unique case (op_q)
            OP_ADD:  res_d = a_q + b_q;
            OP_SUB:  res_d = a_q - b_q;
            OP_XOR:  res_d = a_q ^ b_q;
            OP_AND:  res_d = a_q & b_q;
            default: res_d = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) res_q <= '0;
        else        res_q <= res_d;
    end

    assign res = res_q ^ flip;
endmodule

// File: rtl/lkst_ctrl.sv
module lkst_ctrl
    import lkst_pkg::*;
#(
    parameter int LAG = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cmp_en,
    input  logic err_clr,
    input  logic raw_mismatch,
    output logic err_flag
);
    localparam int CNT_W = $clog2(LAG + 1);
    localparam logic [CNT_W-1:0] FILL_LAST = CNT_W'(LAG - 1);

    chk_state_e       state, state_nx;
    logic [CNT_W-1:0] fill_cnt;
    logic             live;

    assign live = raw_mismatch && cmp_en && (state != CK_FILL);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= CK_FILL;
            fill_cnt <= '0;
        end else begin
            state    <= state_nx;
            fill_cnt <= (state == CK_FILL) ? fill_cnt + 1'b1 : '0;
        end
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            CK_FILL:    if (fill_cnt == FILL_LAST) state_nx = CK_WATCH;
            CK_WATCH:   if (live) state_nx = CK_TRIPPED;
            CK_TRIPPED: if (err_clr && !live) state_nx = CK_WATCH;
            default:    state_nx = CK_FILL;
        endcase
    end

    always_comb begin
        err_flag = (state == CK_TRIPPED) || live;
    end

    // R6
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == CK_TRIPPED && !err_clr) |=> (state == CK_TRIPPED));

    // R8
    mismatch_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        live |=> (state == CK_TRIPPED));

    // R7
    clear_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (err_clr && !live) |=> (state != CK_TRIPPED));

    // R9
    cmp_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cmp_en && state != CK_TRIPPED) |=> (state != CK_TRIPPED));
endmodule

// File: rtl/lockstep_checker.sv
module lockstep_checker
    import lkst_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int LAG    = 2    // legal values: 1 or 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] opd_a,
    input  logic [DATA_W-1:0] opd_b,
    input  logic [1:0]        op_sel,
    input  logic              cmp_en,
    input  logic              err_clr,
    input  logic [DATA_W-1:0] fault_mask,
    output logic [DATA_W-1:0] res_out,
    output logic              err_flag
);
    localparam int IN_W    = 2 * DATA_W + OP_W;
    localparam int CLEAN_W = $clog2(LAG + 2);
    localparam logic [CLEAN_W-1:0] CLEAN_MAX = CLEAN_W'(LAG + 1);

    logic [DATA_W-1:0] pri_res, pri_tap, sh_res;
    logic [IN_W-1:0]   in_now, in_late;
    logic              raw_mismatch;

    lkst_alu #(.DATA_W(DATA_W)) u_primary (
        .clk(clk), .rst_n(rst_n), .a(opd_a), .b(opd_b),
        .op(alu_op_e'(op_sel)), .flip(fault_mask), .res(pri_res)
    );

    assign in_now = {op_sel, opd_a, opd_b};

    lkst_delay #(.WIDTH(IN_W), .DEPTH(LAG)) u_in_dly (
        .clk(clk), .rst_n(rst_n), .d(in_now), .q(in_late)
    );

    lkst_alu #(.DATA_W(DATA_W)) u_shadow (
        .clk(clk), .rst_n(rst_n),
        .a(in_late[2*DATA_W-1:DATA_W]), .b(in_late[DATA_W-1:0]),
        .op(alu_op_e'(in_late[IN_W-1:2*DATA_W])),
        .flip({DATA_W{1'b0}}), .res(sh_res)
    );

    lkst_delay #(.WIDTH(DATA_W), .DEPTH(LAG)) u_out_dly (
        .clk(clk), .rst_n(rst_n), .d(pri_res), .q(pri_tap)
    );

    assign raw_mismatch = (pri_tap != sh_res);
    assign res_out      = pri_res;

    lkst_ctrl #(.LAG(LAG)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .cmp_en(cmp_en), .err_clr(err_clr),
        .raw_mismatch(raw_mismatch), .err_flag(err_flag)
    );

    // Cycles since the last injected fault, saturating.
    logic [CLEAN_W-1:0] clean_cnt;
    always_ff @(posedge clk) begin
        if (!rst_n)                  clean_cnt <= CLEAN_MAX;
        else if (fault_mask != '0)   clean_cnt <= '0;
        else if (clean_cnt != CLEAN_MAX) clean_cnt <= clean_cnt + 1'b1;
    end

    // R5
    no_false_trip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clean_cnt >= CLEAN_W'(LAG)) |-> !raw_mismatch);
endmodule

// File: tb/lockstep_checker_tb.sv
`timescale 1ns/1ps
module lockstep_checker_tb;
    localparam int DATA_W = 8;
    localparam int LAG    = 2;
    localparam int NVEC   = 8;

    // {op[1:0], a[7:0], b[7:0], expected[7:0]}
    localparam logic [25:0] VEC [NVEC] = '{
        {2'd0, 8'h12, 8'h34, 8'h46},
        {2'd1, 8'h10, 8'h20, 8'hF0},
        {2'd2, 8'hAA, 8'h0F, 8'hA5},
        {2'd3, 8'hF0, 8'h3C, 8'h30},
        {2'd0, 8'hFF, 8'h01, 8'h00},
        {2'd1, 8'h00, 8'h01, 8'hFF},
        {2'd2, 8'h55, 8'h55, 8'h00},
        {2'd3, 8'hFF, 8'h81, 8'h81}
    };

    logic              clk = 1'b0;
    logic              rst_n;
    logic [DATA_W-1:0] opd_a, opd_b, fault_mask;
    logic [1:0]        op_sel;
    logic              cmp_en, err_clr;
    logic [DATA_W-1:0] res_out;
    logic              err_flag;

    int n_chk = 0;
    int n_err = 0;
    bit done  = 1'b0;

    always #2.5 clk = ~clk;

    lockstep_checker #(.DATA_W(DATA_W), .LAG(LAG)) u_dut (
        .clk(clk), .rst_n(rst_n), .opd_a(opd_a), .opd_b(opd_b),
        .op_sel(op_sel), .cmp_en(cmp_en), .err_clr(err_clr),
        .fault_mask(fault_mask), .res_out(res_out), .err_flag(err_flag)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_err++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; opd_a = 8'h5A; opd_b = 8'h3C; op_sel = 2'd0;
        cmp_en = 1'b1; err_clr = 1'b0; fault_mask = '0;
        repeat (3) tick();
        chk("R2 res_out in reset", res_out, 0);
        chk("R2 err_flag in reset", err_flag, 0);
        rst_n = 1'b1;
        for (int i = 0; i < LAG; i++) begin
            tick();
            chk("R10 masked fill", err_flag, 0);
        end

        // Vector table walk
        for (int i = 0; i < NVEC + 2; i++) begin
            tick();
            if (i >= 2) begin
                chk("R1 result", res_out, VEC[i-2][7:0]);
                chk("R5 no error", err_flag, 0);
            end
            if (i < NVEC) begin
                op_sel = VEC[i][25:24];
                opd_a  = VEC[i][23:16];
                opd_b  = VEC[i][15:8];
            end
        end

        // Steady operands: 21 + 03 = 24
        op_sel = 2'd0; opd_a = 8'h21; opd_b = 8'h03;
        repeat (4) tick();
        chk("R5 steady no error", err_flag, 0);

        // Single-bit fault, report timing and stickiness
        fault_mask = 8'h04;
        tick();
        chk("R3 corrupted output", res_out, 8'h20);
        chk("R4 not before lag", err_flag, 0);
        fault_mask = '0;
        tick();
        chk("R4 flagged at lag", err_flag, 1);
        chk("R3 output restored", res_out, 8'h24);
        tick();
        chk("R6 sticky", err_flag, 1);
        tick();
        chk("R6 still sticky", err_flag, 1);
        err_clr = 1'b1;
        tick();
        chk("R7 cleared", err_flag, 0);
        err_clr = 1'b0;
        tick();
        chk("R7 stays clear", err_flag, 0);

        // Clear coinciding with a live mismatch
        fault_mask = 8'h80;
        tick();
        fault_mask = '0;
        tick();
        chk("R4 flagged msb", err_flag, 1);
        err_clr = 1'b1;
        tick();
        chk("R8 clear with mismatch", err_flag, 1);
        err_clr = 1'b0;
        tick();
        chk("R8 held after clear", err_flag, 1);
        err_clr = 1'b1;
        tick();
        chk("R7 second clear", err_flag, 0);
        err_clr = 1'b0;

        // Compare disabled
        cmp_en = 1'b0; fault_mask = 8'h01;
        tick();
        fault_mask = '0;
        tick();
        chk("R9 disabled compare", err_flag, 0);
        tick();
        cmp_en = 1'b1;
        tick();
        chk("R9 nothing latched", err_flag, 0);
        chk("R1 output after tests", res_out, 8'h24);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule